// File: doc/BRIEF.md
# PCIe Root-Complex Reset and Power-Up Sequencer

This block brings a PCIe root-complex controller and its PHYs out of reset in a fixed, timed order. After a start request it asserts the slot fundamental reset and the controller's internal reset, turns slot power on, and holds both resets for a programmable power-stable interval. It then releases the resets in turn. Next it opens a window for PHY register programming. To do this it ungates the auxiliary clock, holds the PHYs in reset, and releases the power-up reset. It then hands control to an external PHY-programming engine through a request/done handshake.

When the PHY engine reports completion, the sequencer gates the auxiliary clock off, releases the PHY hold, and ungates the clock again. It then selects root-complex mode by driving the device-type code 4 and raises `done_o`. If the PHY engine reports a timeout, the sequence stops in an error state. A shutdown request re-asserts both link resets from any point, so that the next boot finds a clean link. Link training and the PHY register protocol itself belong to other blocks.

The power-stable interval is `CLK_KHZ * HOLD_MS` clock cycles. With the defaults (250 MHz, 100 ms) this is 25,000,000 cycles.

Top module: `pcie_rst_seq`

## Requirements
- R1: While `rst` is high, and after it falls until a start, every reset output is asserted (`perst_n_o`, `ctrl_rst_n_o` and `pwrup_rst_n_o` low). Slot power, aux clock, PHY hold, PHY request, `busy_o`, `done_o` and `error_o` are all low, and `dev_type_o` is 0.
- R2: A start accepted in the idle, done, error or shutdown state gives one busy cycle. In that cycle both link resets are asserted and slot power, aux clock, PHY hold and power-up release are off. Slot power turns on in the following cycle.
- R3: Slot power stays on with both link resets asserted for exactly `CLK_KHZ*HOLD_MS` cycles before any reset is released.
- R4: `ctrl_rst_n_o` goes high one cycle before `perst_n_o` goes high.
- R5: After the external reset is released, three single-cycle steps follow in order: the aux clock is enabled, then `phy_hold_rst_o` is set, then `pwrup_rst_n_o` goes high. In the next cycle `phy_prog_req_o` rises.
- R6: `phy_prog_req_o` stays high until `phy_prog_done_i` is seen. Four single-cycle steps then follow in order: the aux clock goes off with the request dropped, the PHY hold clears, the aux clock comes back on, and `dev_type_o` becomes 4. In the next cycle `done_o` rises and `busy_o` falls, and the outputs then hold.
- R7: `phy_prog_timeout_i` while the request is high gives, in the next cycle, `error_o`=1, `busy_o`=0 and the request dropped. `dev_type_o` stays 0, and the other outputs keep their request-time values. Timeout wins over a simultaneous done.
- R8: `shutdown_i`, from any state, drives `perst_n_o` and `ctrl_rst_n_o` low and clears `busy_o`, `done_o`, `error_o` and the request in the next cycle. All other outputs keep their values. The block then waits for a new start.
- R9: A start pulse while `busy_o` is high has no effect on the sequence or its timing.
- R10: A start after done, error or shutdown re-runs the whole sequence from R2.
- R11: `phy_prog_done_i` and `phy_prog_timeout_i` have no effect outside the programming step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the power-up sequence |
| shutdown_i | input | 1 | Return the link to reset |
| phy_prog_done_i | input | 1 | PHY programming engine finished |
| phy_prog_timeout_i | input | 1 | PHY programming engine timed out |
| perst_n_o | output | 1 | Slot fundamental reset, active low |
| ctrl_rst_n_o | output | 1 | Controller internal reset, active low |
| slot_pwr_en_o | output | 1 | Slot power enable |
| aux_clk_en_o | output | 1 | Auxiliary clock gate enable |
| phy_hold_rst_o | output | 1 | Hold PHYs in reset |
| pwrup_rst_n_o | output | 1 | Power-up reset, active low |
| dev_type_o | output | 4 | Device type code (4 = root complex) |
| phy_prog_req_o | output | 1 | Request to the PHY programming engine |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| error_o | output | 1 | PHY programming timed out |

## Verification
Every output is registered. A start, done, timeout or shutdown seen at a rising edge therefore shows at the outputs right after that edge. Each later step of the sequence moves the outputs by exactly one edge, except the power-stable wait, which lasts `CLK_KHZ*HOLD_MS` edges. The bench drives inputs on falling edges and compares the full output vector at every following falling edge against the step it expects for that cycle. In this way an early, late, skipped or reordered step shows up as a mismatch at the exact cycle where it happens. The power window is checked cycle by cycle with a reduced clock-rate parameter, so the count is exact rather than a lower bound.

// File: rtl/pcie_rst_seq_pkg.sv
package pcie_rst_seq_pkg;

  localparam int DEV_W       = 4;
  localparam int DEV_TYPE_RC = 4;

  // Encoding order is used by the decode ranges below.
  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_ASRT   = 4'd1,
    S_PWR    = 4'd2,
    S_CREL   = 4'd3,
    S_EREL   = 4'd4,
    S_AUX1   = 4'd5,
    S_HOLD   = 4'd6,
    S_PUP    = 4'd7,
    S_PROG   = 4'd8,
    S_AUXOFF = 4'd9,
    S_UNHOLD = 4'd10,
    S_AUX2   = 4'd11,
    S_TYPE   = 4'd12,
    S_DONE   = 4'd13,
    S_ERR    = 4'd14,
    S_SHUT   = 4'd15
  } seq_state_e;

  typedef struct packed {
    logic             perst_n;
    logic             ctrl_rst_n;
    logic             slot_pwr;
    logic             aux_clk_en;
    logic             phy_hold;
    logic             pwrup_rst_n;
    logic             phy_req;
    logic             busy;
    logic             done;
    logic             err;
    logic [DEV_W-1:0] dev_type;
  } seq_out_t;

  function automatic seq_out_t state_outputs(seq_state_e s);
    seq_out_t o;
    o             = '0;
    o.slot_pwr    = s inside {[S_PWR:S_ERR]};
    o.ctrl_rst_n  = s inside {[S_CREL:S_ERR]};
    o.perst_n     = s inside {[S_EREL:S_ERR]};
    o.aux_clk_en  = s inside {[S_AUX1:S_PROG], [S_AUX2:S_ERR]};
    o.phy_hold    = s inside {[S_HOLD:S_AUXOFF], S_ERR};
    o.pwrup_rst_n = s inside {[S_PUP:S_ERR]};
    o.phy_req     = (s == S_PROG);
    o.busy        = s inside {[S_ASRT:S_TYPE]};
    o.done        = (s == S_DONE);
    o.err         = (s == S_ERR);
    o.dev_type    = (s inside {S_TYPE, S_DONE}) ? DEV_W'(DEV_TYPE_RC) : '0;
    return o;
  endfunction

endpackage

// File: rtl/pcie_rst_seq_timer.sv
module pcie_rst_seq_timer #(
  parameter int unsigned CYCLES = 25000000
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CW'(CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pcie_rst_seq_fsm.sv
module pcie_rst_seq_fsm
  import pcie_rst_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start_i,
  input  logic     shutdown_i,
  input  logic     prog_done_i,
  input  logic     prog_timeout_i,
  input  logic     wait_expired_i,
  output logic     wait_load_o,
  output seq_out_t outs_o
);
  seq_state_e state_q, state_d;
  seq_out_t   out_q, shut_view;

  always_comb begin
    state_d = state_q;
    if (shutdown_i) begin
      state_d = S_SHUT;
    end else begin
      case (state_q)
        S_IDLE, S_DONE, S_ERR, S_SHUT: if (start_i) state_d = S_ASRT;
        S_ASRT:   state_d = S_PWR;
        S_PWR:    if (wait_expired_i) state_d = S_CREL;
        S_CREL:   state_d = S_EREL;
        S_EREL:   state_d = S_AUX1;
        S_AUX1:   state_d = S_HOLD;
        S_HOLD:   state_d = S_PUP;
        S_PUP:    state_d = S_PROG;
        S_PROG: begin
          if (prog_timeout_i)   state_d = S_ERR;
          else if (prog_done_i) state_d = S_AUXOFF;
        end
        S_AUXOFF: state_d = S_UNHOLD;
        S_UNHOLD: state_d = S_AUX2;
        S_AUX2:   state_d = S_TYPE;
        S_TYPE:   state_d = S_DONE;
        default:  state_d = S_IDLE;
      endcase
    end
  end

  // Shutdown keeps everything except the link resets and status.
  always_comb begin
    shut_view            = out_q;
    shut_view.perst_n    = 1'b0;
    shut_view.ctrl_rst_n = 1'b0;
    shut_view.phy_req    = 1'b0;
    shut_view.busy       = 1'b0;
    shut_view.done       = 1'b0;
    shut_view.err        = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      out_q   <= state_outputs(S_IDLE);
    end else begin
      state_q <= state_d;
      out_q   <= (state_d == S_SHUT) ? shut_view : state_outputs(state_d);
    end
  end

  assign wait_load_o = (state_q == S_ASRT);
  assign outs_o      = out_q;
endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq
  import pcie_rst_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 250000,
  parameter int unsigned HOLD_MS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             shutdown_i,
  input  logic             phy_prog_done_i,
  input  logic             phy_prog_timeout_i,
  output logic             perst_n_o,
  output logic             ctrl_rst_n_o,
  output logic             slot_pwr_en_o,
  output logic             aux_clk_en_o,
  output logic             phy_hold_rst_o,
  output logic             pwrup_rst_n_o,
  output logic [DEV_W-1:0] dev_type_o,
  output logic             phy_prog_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);
  localparam int unsigned WAIT_CYC = CLK_KHZ * HOLD_MS;

  logic     wait_load, wait_expired;
  seq_out_t outs;

  pcie_rst_seq_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (wait_load),
    .expired_o (wait_expired)
  );

  pcie_rst_seq_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .shutdown_i     (shutdown_i),
    .prog_done_i    (phy_prog_done_i),
    .prog_timeout_i (phy_prog_timeout_i),
    .wait_expired_i (wait_expired),
    .wait_load_o    (wait_load),
    .outs_o         (outs)
  );

  assign perst_n_o      = outs.perst_n;
  assign ctrl_rst_n_o   = outs.ctrl_rst_n;
  assign slot_pwr_en_o  = outs.slot_pwr;
  assign aux_clk_en_o   = outs.aux_clk_en;
  assign phy_hold_rst_o = outs.phy_hold;
  assign pwrup_rst_n_o  = outs.pwrup_rst_n;
  assign dev_type_o     = outs.dev_type;
  assign phy_prog_req_o = outs.phy_req;
  assign busy_o         = outs.busy;
  assign done_o         = outs.done;
  assign error_o        = outs.err;
endmodule

// File: rtl/pcie_rst_seq_chk.sv
module pcie_rst_seq_chk #(
  parameter int unsigned WAIT_CYC = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       shutdown_i,
  input logic       phy_prog_timeout_i,
  input logic       perst_n_o,
  input logic       ctrl_rst_n_o,
  input logic       slot_pwr_en_o,
  input logic       aux_clk_en_o,
  input logic       phy_hold_rst_o,
  input logic       pwrup_rst_n_o,
  input logic [3:0] dev_type_o,
  input logic       phy_prog_req_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       error_o
);
  int unsigned pwr_cnt;

  always_ff @(posedge clk) begin
    if (rst || !slot_pwr_en_o || ctrl_rst_n_o) pwr_cnt <= 0;
    else                                       pwr_cnt <= pwr_cnt + 1;
  end

  AST_PWR_ON_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(slot_pwr_en_o) |-> (!perst_n_o && !ctrl_rst_n_o)); // R2
  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_rst_n_o) |-> (pwr_cnt == WAIT_CYC)); // R3
  AST_CTRL_BEFORE_EXT: assert property (@(posedge clk) disable iff (rst)
    $rose(perst_n_o) |-> $past(ctrl_rst_n_o)); // R4
  AST_PUP_UNDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(pwrup_rst_n_o) |-> (phy_hold_rst_o && aux_clk_en_o)); // R5
  AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (rst)
    phy_prog_req_o |-> (pwrup_rst_n_o && phy_hold_rst_o && perst_n_o)); // R5
  AST_TYPE_AFTER_UNHOLD: assert property (@(posedge clk) disable iff (rst)
    (dev_type_o != 4'd0) |-> (!phy_hold_rst_o && aux_clk_en_o)); // R6
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_o, done_o, error_o})); // R7
  AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (rst)
    (phy_prog_req_o && phy_prog_timeout_i && !shutdown_i) |=> error_o); // R7
  AST_SHUTDOWN_RST: assert property (@(posedge clk) disable iff (rst)
    shutdown_i |=> (!perst_n_o && !ctrl_rst_n_o && !busy_o)); // R8
endmodule

bind pcie_rst_seq pcie_rst_seq_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk                (clk),
  .rst                (rst),
  .shutdown_i         (shutdown_i),
  .phy_prog_timeout_i (phy_prog_timeout_i),
  .perst_n_o          (perst_n_o),
  .ctrl_rst_n_o       (ctrl_rst_n_o),
  .slot_pwr_en_o      (slot_pwr_en_o),
  .aux_clk_en_o       (aux_clk_en_o),
  .phy_hold_rst_o     (phy_hold_rst_o),
  .pwrup_rst_n_o      (pwrup_rst_n_o),
  .dev_type_o         (dev_type_o),
  .phy_prog_req_o     (phy_prog_req_o),
  .busy_o             (busy_o),
  .done_o             (done_o),
  .error_o            (error_o)
);

// File: tb/pcie_rst_seq_bench.sv
module pcie_rst_seq_bench;
  localparam int CLK_KHZ = 1;
  localparam int HOLD_MS = 20;
  localparam int WAIT    = CLK_KHZ * HOLD_MS;

  // {perst_n, ctrl_rst_n, pwr, aux, hold, pwrup_n, req, busy, done, err, dev[3:0]}
  localparam logic [13:0] V_IDLE     = 14'b0000000_000_0000;
  localparam logic [13:0] V_ASRT     = 14'b0000000_100_0000;
  localparam logic [13:0] V_PWR      = 14'b0010000_100_0000;
  localparam logic [13:0] V_CREL     = 14'b0110000_100_0000;
  localparam logic [13:0] V_EREL     = 14'b1110000_100_0000;
  localparam logic [13:0] V_AUX1     = 14'b1111000_100_0000;
  localparam logic [13:0] V_HOLD     = 14'b1111100_100_0000;
  localparam logic [13:0] V_PUP      = 14'b1111110_100_0000;
  localparam logic [13:0] V_PROG     = 14'b1111111_100_0000;
  localparam logic [13:0] V_AUXOFF   = 14'b1110110_100_0000;
  localparam logic [13:0] V_UNHOLD   = 14'b1110010_100_0000;
  localparam logic [13:0] V_AUX2     = 14'b1111010_100_0000;
  localparam logic [13:0] V_TYPE     = 14'b1111010_100_0100;
  localparam logic [13:0] V_DONE     = 14'b1111010_010_0100;
  localparam logic [13:0] V_ERR      = 14'b1111110_001_0000;
  localparam logic [13:0] V_SHUT_DN  = 14'b0011010_000_0100;
  localparam logic [13:0] V_SHUT_PWR = 14'b0010000_000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, shutdown_i = 1'b0;
  logic phy_prog_done_i = 1'b0, phy_prog_timeout_i = 1'b0;
  logic perst_n_o, ctrl_rst_n_o, slot_pwr_en_o, aux_clk_en_o;
  logic phy_hold_rst_o, pwrup_rst_n_o, phy_prog_req_o, busy_o, done_o, error_o;
  logic [3:0] dev_type_o;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pcie_rst_seq #(.CLK_KHZ(CLK_KHZ), .HOLD_MS(HOLD_MS)) u_pcie_rst_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .shutdown_i(shutdown_i),
    .phy_prog_done_i(phy_prog_done_i), .phy_prog_timeout_i(phy_prog_timeout_i),
    .perst_n_o(perst_n_o), .ctrl_rst_n_o(ctrl_rst_n_o), .slot_pwr_en_o(slot_pwr_en_o),
    .aux_clk_en_o(aux_clk_en_o), .phy_hold_rst_o(phy_hold_rst_o),
    .pwrup_rst_n_o(pwrup_rst_n_o), .dev_type_o(dev_type_o),
    .phy_prog_req_o(phy_prog_req_o), .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  function automatic logic [13:0] obs();
    return {perst_n_o, ctrl_rst_n_o, slot_pwr_en_o, aux_clk_en_o, phy_hold_rst_o,
            pwrup_rst_n_o, phy_prog_req_o, busy_o, done_o, error_o, dev_type_o};
  endfunction

  task automatic chk(string req, logic [13:0] exp);
    checks++;
    if (obs() !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, obs(), exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Start through to the request cycle; optional stray inputs while waiting.
  task automatic to_prog(bit poke_start, bit stray);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk("R2 first busy cycle resets on, power off", V_ASRT);
    for (int i = 0; i < WAIT; i++) begin
      if (poke_start && i == 5) start_i = 1'b1;
      if (stray && i == 7) begin
        phy_prog_done_i    = 1'b1;
        phy_prog_timeout_i = 1'b1;
      end
      tick();
      start_i = 1'b0;
      phy_prog_done_i    = 1'b0;
      phy_prog_timeout_i = 1'b0;
      if (i == 0) chk("R2 power on after reset cycle", V_PWR);
      else if (poke_start) chk("R9 start while busy ignored", V_PWR);
      else if (stray) chk("R11 stray done/timeout ignored", V_PWR);
      else chk("R3 power window with resets held", V_PWR);
    end
    tick(); chk("R4 controller reset released first", V_CREL);
    tick(); chk("R4 external reset released second", V_EREL);
    tick(); chk("R5 aux clock on", V_AUX1);
    tick(); chk("R5 phy hold set", V_HOLD);
    tick(); chk("R5 power-up reset released", V_PUP);
    tick(); chk("R5 phy request raised", V_PROG);
  endtask

  task automatic finish_prog(int delay);
    for (int i = 0; i < delay; i++) begin
      tick(); chk("R6 request held until done", V_PROG);
    end
    phy_prog_done_i = 1'b1;
    tick();
    phy_prog_done_i = 1'b0;
    chk("R6 aux clock off", V_AUXOFF);
    tick(); chk("R6 phy hold cleared", V_UNHOLD);
    tick(); chk("R6 aux clock back on", V_AUX2);
    tick(); chk("R6 device type 4", V_TYPE);
    tick(); chk("R6 done raised", V_DONE);
    tick(); chk("R6 done holds", V_DONE);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 state during reset", V_IDLE);
    rst = 1'b0;
    tick(); tick();
    chk("R1 idle after reset", V_IDLE);
  endtask

  task automatic t_boot_clean();
    to_prog(1'b0, 1'b0);
    finish_prog(3);
  endtask

  task automatic t_boot_noisy();
    // R10 restart from done, with R9 and R11 stimulus
    to_prog(1'b1, 1'b0);
    finish_prog(0);
    to_prog(1'b0, 1'b1);
    finish_prog(1);
  endtask

  task automatic t_shutdown_done();
    shutdown_i = 1'b1;
    tick();
    shutdown_i = 1'b0;
    chk("R8 shutdown from done", V_SHUT_DN);
    repeat (5) tick();
    chk("R8 stays shut", V_SHUT_DN);
  endtask

  task automatic t_timeout();
    to_prog(1'b0, 1'b0);
    tick(); chk("R7 request before timeout", V_PROG);
    phy_prog_timeout_i = 1'b1;
    phy_prog_done_i    = 1'b1;
    tick();
    phy_prog_timeout_i = 1'b0;
    phy_prog_done_i    = 1'b0;
    chk("R7 timeout gives error", V_ERR);
    phy_prog_done_i = 1'b1;
    tick();
    phy_prog_done_i = 1'b0;
    chk("R11 done after error ignored", V_ERR);
  endtask

  task automatic t_shutdown_wait();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk("R10 restart after error", V_ASRT);
    repeat (4) tick();
    shutdown_i = 1'b1;
    tick();
    shutdown_i = 1'b0;
    chk("R8 shutdown during power window", V_SHUT_PWR);
    repeat (WAIT + 10) tick();
    chk("R8 no release after shutdown", V_SHUT_PWR);
    to_prog(1'b0, 1'b0);
    finish_prog(2);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_boot_clean();
    t_boot_noisy();
    t_shutdown_done();
    t_timeout();
    t_shutdown_wait();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule